// File: doc/BRIEF.md
# Omega Destination-Tag Router

This block is a self-routing multistage interconnect for a parameterized number of ports (a power of two, eight by default). Every pass, each input may present a request made of a valid bit, a destination tag and a payload. The requests cross log2(PORTS) columns of two-by-two switches with a perfect-shuffle wiring in front of each column. Each switch sets itself from one bit of the tag. Routing is combinational through the whole network, and the results are captured in output registers, so a pass completes in one clock.

Two requests can need the same switch output in one column. When that happens, the request on the switch's upper input keeps the path. The other request is dropped for that pass and reported on a per-input blocked flag, so the caller can present it again on a later pass. A request can also carry a broadcast flag. A broadcast sets every switch it reaches to copy its input to both outputs, so its payload arrives on all outputs. Each output carries the index of the input it came from, so a consumer can tell where each payload originated.

Top module: `omega_router`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_src`, `out_data` and `req_blocked` are all zero, whatever the inputs are.
- R2: The result of a pass appears on the outputs after the first rising clock edge that samples its inputs, and stays there until the next edge.
- R3: A unicast request from input i with tag d that is not blocked appears on output d with `out_src` slot d equal to i. Output slot k sits at bits [k*TAG_W +: TAG_W] of `out_src` and at bits [k*DATA_W +: DATA_W] of `out_data`. Column s (0 is nearest the inputs) steers by tag bit TAG_W-1-s: 0 selects the upper switch output and 1 selects the lower one.
- R4: When two unicast requests need the same output of one switch, the request on the upper input wins and the other request's bit in `req_blocked` is set. In column s, the upper input holds the request whose source-index bit TAG_W-1-s is 0. It follows that input 0 is never blocked by a unicast conflict.
- R5: A blocked request drives no output in that pass. Every output it would have reached is either invalid or carries another request's source and payload. In a unicast pass, the number of valid outputs plus the number of blocked flags equals the number of valid inputs.
- R6: A set of requests with no switch conflict (for example identity, or a cyclic shift by one) is delivered completely, with `req_blocked` all zero.
- R7: If any valid input has its bit in `in_bcast` set, the lowest-indexed such input is broadcast. All outputs become valid with that source and payload, and every other valid input is blocked.
- R8: An input whose `in_valid` bit is 0 produces no output and is never flagged blocked, even when its broadcast bit or tag is set.
- R9: A pass with at least one valid request delivers at least one. Presenting only the blocked subset again, pass after pass, therefore completes any permutation within PORTS passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | PORTS | Request present, one bit per input |
| in_bcast | input | PORTS | Request is a broadcast, one bit per input |
| in_dest | input | PORTS*TAG_W | Destination tags, input k at [k*TAG_W +: TAG_W] |
| in_data | input | PORTS*DATA_W | Payloads, input k at [k*DATA_W +: DATA_W] |
| out_valid | output | PORTS | Output carries a delivered payload |
| out_src | output | PORTS*TAG_W | Source input index per output |
| out_data | output | PORTS*DATA_W | Delivered payload per output |
| req_blocked | output | PORTS | Input request lost a switch conflict or yielded to a broadcast |

## Verification
The identity permutation and a cyclic shift are used to show that conflict-free patterns pass whole. A hand-built pair that collides in the first column tells the upper-wins rule apart from any other tie-break. Bit reversal and shuffled permutations are retried on their blocked subsets until done, which exercises conflicts deep in the network and the progress guarantee. Broadcast passes, including two competing broadcasts and invalid inputs with tags and broadcast bits set, separate the broadcast priority from the ignore rule. A long run of pseudo-random sparse request mixes is compared pass by pass against a model that walks each request's path by switch position.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: rotate a line index left by one within w bits.
  function automatic int unsigned shuffle_pos(input int unsigned pos, input int unsigned w);
    return ((pos << 1) | (pos >> (w - 1))) & ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/omega_inject.sv
module omega_inject #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]         in_valid,
  input  logic [N-1:0]         in_bcast,
  output logic                 bc_on,
  output logic [N-1:0]         o_vld,
  output logic [N-1:0][TW-1:0] o_src,
  output logic [N-1:0]         o_lost
);

  logic [N-1:0] bc_req;
  logic [N-1:0] bc_pick;

  assign bc_req = in_valid & in_bcast;

  // Lowest-indexed broadcast request is admitted alone.
  always_comb begin : bcast_pick
    bc_pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bc_req[i]) begin
        bc_pick    = '0;
        bc_pick[i] = 1'b1;
      end
    end
  end

  always_comb begin : lane_load
    bc_on = |bc_req;
    for (int i = 0; i < N; i++) begin
      o_src[i] = TW'(i);
    end
    if (bc_on) begin
      o_vld  = bc_pick;
      o_lost = in_valid & ~bc_pick;
    end else begin
      o_vld  = in_valid;
      o_lost = '0;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic                 bc_on,
  input  logic [N-1:0]         i_vld,
  input  logic [N-1:0][TW-1:0] i_src,
  input  logic [N-1:0]         i_col,
  output logic [N-1:0]         o_vld,
  output logic [N-1:0][TW-1:0] o_src,
  output logic [N-1:0]         o_lost
);
  import omega_pkg::*;

  logic [N-1:0]         sh_vld;
  logic [N-1:0][TW-1:0] sh_src;

  always_comb begin : perfect_shuffle
    sh_vld = '0;
    sh_src = '0;
    for (int p = 0; p < N; p++) begin
      sh_vld[shuffle_pos(p, TW)] = i_vld[p];
      sh_src[shuffle_pos(p, TW)] = i_src[p];
    end
  end

  always_comb begin : switch_column
    logic up_b;
    logic lo_b;
    int   up_o;
    int   lo_o;
    o_vld  = '0;
    o_src  = '0;
    o_lost = '0;
    for (int j = 0; j < N / 2; j++) begin
      up_b = i_col[sh_src[2*j]];
      lo_b = i_col[sh_src[2*j+1]];
      up_o = 2 * j + (up_b ? 1 : 0);
      lo_o = 2 * j + (lo_b ? 1 : 0);
      if (bc_on) begin
        // broadcast setting: the single live input feeds both outputs
        if (sh_vld[2*j] || sh_vld[2*j+1]) begin
          o_vld[2*j]   = 1'b1;
          o_vld[2*j+1] = 1'b1;
          o_src[2*j]   = sh_vld[2*j] ? sh_src[2*j] : sh_src[2*j+1];
          o_src[2*j+1] = sh_vld[2*j] ? sh_src[2*j] : sh_src[2*j+1];
        end
      end else begin
        if (sh_vld[2*j]) begin
          o_vld[up_o] = 1'b1;
          o_src[up_o] = sh_src[2*j];
        end
        if (sh_vld[2*j+1]) begin
          if (sh_vld[2*j] && (up_b == lo_b)) begin
            o_lost[sh_src[2*j+1]] = 1'b1;
          end else begin
            o_vld[lo_o] = 1'b1;
            o_src[lo_o] = sh_src[2*j+1];
          end
        end
      end
    end
  end

endmodule

// File: rtl/omega_router.sv
module omega_router #(
  parameter int PORTS  = 8,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [PORTS-1:0]                  in_valid,
  input  logic [PORTS-1:0]                  in_bcast,
  input  logic [PORTS*$clog2(PORTS)-1:0]    in_dest,
  input  logic [PORTS*DATA_W-1:0]           in_data,
  output logic [PORTS-1:0]                  out_valid,
  output logic [PORTS*$clog2(PORTS)-1:0]    out_src,
  output logic [PORTS*DATA_W-1:0]           out_data,
  output logic [PORTS-1:0]                  req_blocked
);

  localparam int TAG_W = $clog2(PORTS);

  logic [PORTS-1:0][TAG_W-1:0]  dest_w;
  logic [PORTS-1:0][DATA_W-1:0] data_w;
  logic                         bc_on;
  logic [PORTS-1:0]             lane_vld [TAG_W+1];
  logic [PORTS-1:0][TAG_W-1:0]  lane_src [TAG_W+1];
  logic [PORTS-1:0]             lane_lost [TAG_W+1];
  logic [PORTS-1:0]             tag_col [TAG_W];

  logic [PORTS-1:0]             nxt_vld, vld_q;
  logic [PORTS-1:0][TAG_W-1:0]  nxt_src, src_q;
  logic [PORTS-1:0][DATA_W-1:0] nxt_dat, dat_q;
  logic [PORTS-1:0]             nxt_blk, blk_q;

  assign dest_w = in_dest;
  assign data_w = in_data;

  // Column s steers on tag bit TAG_W-1-s, gathered per source.
  always_comb begin : tag_columns
    for (int s = 0; s < TAG_W; s++) begin
      for (int i = 0; i < PORTS; i++) begin
        tag_col[s][i] = dest_w[i][TAG_W-1-s];
      end
    end
  end

  omega_inject #(.N(PORTS), .TW(TAG_W)) u_inject (
    .in_valid (in_valid),
    .in_bcast (in_bcast),
    .bc_on    (bc_on),
    .o_vld    (lane_vld[0]),
    .o_src    (lane_src[0]),
    .o_lost   (lane_lost[0])
  );

  for (genvar s = 0; s < TAG_W; s++) begin : g_col
    omega_stage #(.N(PORTS), .TW(TAG_W)) u_stage (
      .bc_on  (bc_on),
      .i_vld  (lane_vld[s]),
      .i_src  (lane_src[s]),
      .i_col  (tag_col[s]),
      .o_vld  (lane_vld[s+1]),
      .o_src  (lane_src[s+1]),
      .o_lost (lane_lost[s+1])
    );
  end

  always_comb begin : next_state
    nxt_vld = lane_vld[TAG_W];
    nxt_src = lane_src[TAG_W];
    nxt_blk = '0;
    for (int s = 0; s <= TAG_W; s++) begin
      nxt_blk = nxt_blk | lane_lost[s];
    end
    for (int p = 0; p < PORTS; p++) begin
      nxt_dat[p] = lane_vld[TAG_W][p] ? data_w[lane_src[TAG_W][p]] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : out_regs
    if (!rst_n) begin
      vld_q <= '0;
      src_q <= '0;
      dat_q <= '0;
      blk_q <= '0;
    end else begin
      vld_q <= nxt_vld;
      src_q <= nxt_src;
      dat_q <= nxt_dat;
      blk_q <= nxt_blk;
    end
  end

  assign out_valid   = vld_q;
  assign out_src     = src_q;
  assign out_data    = dat_q;
  assign req_blocked = blk_q;

endmodule

// File: rtl/omega_router_chk.sv
module omega_router_chk #(
  parameter int PORTS  = 8,
  parameter int DATA_W = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [PORTS-1:0]               in_valid,
  input logic [PORTS-1:0]               in_bcast,
  input logic [PORTS*$clog2(PORTS)-1:0] in_dest,
  input logic [PORTS-1:0]               out_valid,
  input logic [PORTS*$clog2(PORTS)-1:0] out_src,
  input logic [PORTS-1:0]               req_blocked
);

  localparam int TAG_W = $clog2(PORTS);

  logic                        armed;
  logic [PORTS-1:0]            prev_valid;
  logic [PORTS-1:0]            prev_bcast;
  logic [PORTS-1:0][TAG_W-1:0] prev_dest;
  logic                        prev_bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      prev_valid <= '0;
      prev_bcast <= '0;
      prev_dest  <= '0;
    end else begin
      armed      <= 1'b1;
      prev_valid <= in_valid;
      prev_bcast <= in_bcast;
      prev_dest  <= in_dest;
    end
  end

  assign prev_bc = |(prev_valid & prev_bcast);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (out_valid == '0 && req_blocked == '0);
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_out
    p_tag_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !prev_bc && out_valid[p]) |->
        (prev_dest[out_src[p*TAG_W +: TAG_W]] == TAG_W'(p)));
  end

  p_upper_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !prev_bc && prev_valid[0]) |-> !req_blocked[0]);

  p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !prev_bc) |->
      ($countones(out_valid) + $countones(req_blocked) == $countones(prev_valid)));

  p_bcast_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_bc) |-> (&out_valid));

  p_bcast_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_bc) |-> ($countones(req_blocked) + 1 == $countones(prev_valid)));

  p_idle_unblocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((req_blocked & ~prev_valid) == '0));

  p_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (|prev_valid)) |-> (|out_valid));

endmodule

bind omega_router omega_router_chk #(.PORTS(PORTS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_bcast    (in_bcast),
  .in_dest     (in_dest),
  .out_valid   (out_valid),
  .out_src     (out_src),
  .req_blocked (req_blocked)
);

// File: tb/omega_router_test.sv
`timescale 1ns/1ps
module omega_router_test;
  localparam int N  = 8;
  localparam int TW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    in_valid, in_bcast;
  logic [N*TW-1:0] in_dest;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    out_valid, req_blocked;
  logic [N*TW-1:0] out_src;
  logic [N*DW-1:0] out_data;

  omega_router #(.PORTS(N), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bcast(in_bcast),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_src(out_src), .out_data(out_data), .req_blocked(req_blocked)
  );

  typedef struct packed {
    logic [N-1:0]         vld;
    logic [N-1:0]         blk;
    logic [N-1:0][TW-1:0] src;
    logic [N-1:0][DW-1:0] dat;
    logic [3:0]           tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h1234_5678;

  logic [N-1:0]  cv, cb;
  int            cd[N];
  logic [DW-1:0] cdat[N];

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // line a request occupies after column s
  function automatic int line_at(input int src, input int dst, input int s);
    return ((src << (s + 1)) | (dst >> (TW - 1 - s))) & (N - 1);
  endfunction

  task automatic drive(input int tag, output logic [N-1:0] blk_out);
    exp_t e;
    bit   alive[N];
    int   bw;
    e = '0;
    e.tag = 4'(tag);
    bw = -1;
    for (int i = 0; i < N; i++) if (cv[i] && cb[i] && bw < 0) bw = i;
    if (bw >= 0) begin
      for (int p = 0; p < N; p++) begin
        e.vld[p] = 1'b1; e.src[p] = TW'(bw); e.dat[p] = cdat[bw];
      end
      for (int i = 0; i < N; i++) e.blk[i] = cv[i] && (i != bw);
    end else begin
      for (int i = 0; i < N; i++) alive[i] = cv[i];
      for (int s = 0; s < TW; s++)
        for (int a = 0; a < N; a++)
          for (int b = a + 1; b < N; b++)
            if (alive[a] && alive[b] && line_at(a, cd[a], s) == line_at(b, cd[b], s)) begin
              if (((a >> (TW - 1 - s)) & 1) == 1) begin alive[a] = 0; e.blk[a] = 1'b1; end
              else begin alive[b] = 0; e.blk[b] = 1'b1; end
            end
      for (int i = 0; i < N; i++)
        if (alive[i]) begin
          e.vld[cd[i]] = 1'b1; e.src[cd[i]] = TW'(i); e.dat[cd[i]] = cdat[i];
        end
    end
    @(negedge clk);
    in_valid = cv;
    in_bcast = cb;
    for (int i = 0; i < N; i++) begin
      in_dest[i*TW +: TW] = TW'(cd[i]);
      in_data[i*DW +: DW] = cdat[i];
    end
    sb.push_back(e);
    blk_out = e.blk;
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    bit   ok_s, ok_d;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(out_valid == e.vld, tag_name(e.tag), "out_valid", 128'(out_valid), 128'(e.vld));
        ok_s = 1; ok_d = 1;
        for (int p = 0; p < N; p++)
          if (e.vld[p]) begin
            if (out_src[p*TW +: TW] != e.src[p]) ok_s = 0;
            if (out_data[p*DW +: DW] != e.dat[p]) ok_d = 0;
          end
        check(ok_s, "R3", "out_src", 128'(out_src), 128'(e.src));
        check(ok_d, "R5", "out_data", out_data, 128'(e.dat));
        check(req_blocked == e.blk, "R4", "req_blocked", 128'(req_blocked), 128'(e.blk));
      end
    end
  end

  task automatic set_data(input int pass);
    for (int i = 0; i < N; i++) cdat[i] = DW'((pass << 8) | (i * 17) | 16'h8000);
  endtask

  task automatic retry_perm(input int perm[N], input int pass_base);
    logic [N-1:0] pend, blk;
    int passes;
    pend = '1;
    passes = 0;
    while (pend != '0 && passes <= N) begin
      cv = pend; cb = '0;
      for (int i = 0; i < N; i++) cd[i] = perm[i];
      set_data(pass_base + passes);
      drive(9, blk);
      pend = blk;
      passes++;
    end
    check(pend == '0 && passes <= N, "R9", "retry passes", 128'(passes), 128'(N));
  endtask

  logic [N-1:0] blk_tmp;

  initial begin
    int perm[N];
    in_valid = '1; in_bcast = '0; in_dest = '1; in_data = '1;
    cv = '0; cb = '0;
    for (int i = 0; i < N; i++) begin cd[i] = 0; cdat[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == '0 && req_blocked == '0, "R1", "reset outputs",
          128'({out_valid, req_blocked}), 128'(0));
    check(out_data == '0 && out_src == '0, "R1", "reset data", out_data, 128'(0));
    @(negedge clk);
    in_valid = '0;
    #1 rst_n = 1'b1;

    // identity, conflict-free
    cv = '1; cb = '0;
    for (int i = 0; i < N; i++) cd[i] = i;
    set_data(1);
    drive(6, blk_tmp);
    @(posedge clk); #1;
    check(out_valid == 8'hff && req_blocked == '0, "R6", "identity",
          128'({out_valid, req_blocked}), 128'(16'hff00));

    // latency: old result still held before the edge
    cv = 8'h01; cd[0] = 5; set_data(2);
    drive(2, blk_tmp);
    #1;
    check(out_valid == 8'hff, "R2", "held before edge", 128'(out_valid), 128'(8'hff));
    @(posedge clk); #1;
    check(out_valid == 8'h20, "R2", "after edge", 128'(out_valid), 128'(8'h20));

    // cyclic shift
    cv = '1;
    for (int i = 0; i < N; i++) cd[i] = (i + 1) % N;
    set_data(3);
    drive(6, blk_tmp);

    // hand conflict: inputs 0 and 4 collide in column 0
    cv = 8'h11; cd[0] = 3; cd[4] = 1; set_data(4);
    drive(4, blk_tmp);
    @(posedge clk); #1;
    check(out_valid == 8'h08 && req_blocked == 8'h10, "R4", "upper wins",
          128'({out_valid, req_blocked}), 128'(16'h0810));
    check(out_src[3*TW +: TW] == 0, "R5", "loser absent", 128'(out_src), 128'(0));

    // broadcast from 5
    cv = '1; cb = 8'h20;
    for (int i = 0; i < N; i++) cd[i] = i;
    set_data(5);
    drive(7, blk_tmp);
    @(posedge clk); #1;
    check(out_valid == 8'hff && req_blocked == 8'hdf, "R7", "broadcast",
          128'({out_valid, req_blocked}), 128'(16'hffdf));

    // two broadcasts, lowest wins
    cv = 8'h5b; cb = 8'h48; set_data(6);
    drive(7, blk_tmp);
    @(posedge clk); #1;
    check(out_src[6*TW +: TW] == 3 && req_blocked == 8'h53, "R7", "lowest broadcast",
          128'({out_src, req_blocked}), 128'(3));

    // invalid inputs with broadcast and tags set
    cv = 8'h0f; cb = 8'hf0;
    for (int i = 0; i < N; i++) cd[i] = (2 * i) % N;
    set_data(7);
    drive(8, blk_tmp);
    @(posedge clk); #1;
    check(out_valid != 8'hff && (req_blocked & 8'hf0) == 0, "R8", "invalid ignored",
          128'({out_valid, req_blocked}), 128'(0));

    // bit reversal and shuffled permutations with retry
    for (int i = 0; i < N; i++) perm[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
    retry_perm(perm, 10);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < N; i++) perm[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j, t;
        j = int'(rnd() % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      retry_perm(perm, 20 + k * 10);
    end

    // random mixes
    for (int k = 0; k < 60; k++) begin
      cv = N'(rnd());
      cb = '0;
      if (rnd() % 8 == 0) cb[rnd() % N] = 1'b1;
      for (int i = 0; i < N; i++) begin
        cd[i] = int'(rnd() % N);
        cdat[i] = DW'(rnd());
      end
      drive(3, blk_tmp);
    end

    @(negedge clk);
    in_valid = '0;
    repeat (3) @(posedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule